// File: doc/BRIEF.md
# Serial Control Port Register Interface

This block is a four-wire serial slave through which an external host programs and reads back a bank of 8-bit configuration registers. The host pulls an active-low select low, sets a direction input, and clocks sixteen bits on one serial data line. The first eight bits carry a register address and the next eight carry the data, each most significant bit first. For a write, the block accepts the data from the host. For a read, the block takes the line over after the address and shifts the selected register's contents back out.

The serial clock, data, select and direction inputs are asynchronous to the master clock. Each one passes through a two-flop synchroniser, and all edge detection happens in the master-clock domain. To leave margin for this, every high and low phase of the serial clock must last at least four master-clock cycles, and the serial clock must idle low.

The address space gives 32 register slots. Two of those slots each lead to a pair of physical registers. Each pair has its own toggle flag, and consecutive writes to that address alternate between the two registers. This gives 34 registers in total. The whole bank is presented as one flat output vector for the rest of the chip.

Top module: `scp_regif`

## Requirements
- R1: A transfer is 16 rising serial-clock edges while select is low. The first 8 bits are the address and the last 8 bits are the data, both MSB first. A write transfer stores the data into the register chosen by address bits 6:2.
- R2: Address bits 1:0 have no effect on which register is reached.
- R3: The direction input is sampled at the first rising edge: 1 means read and 0 means write. A read transfer never changes any register or toggle flag.
- R4: If select goes high before the 16th rising edge, no register is changed. Rising edges after the 16th are ignored, and the stored value comes from the first 16 bits.
- R5: While select is high, the transfer state is held cleared, `sd_oe` is 0, and activity on the serial clock, data and direction inputs has no effect.
- R6: In a read, `sd_oe` rises at the first falling serial-clock edge after the 8th address bit. From then on, `sd_out` presents the register MSB first, advancing one bit on each later falling edge. `sd_oe` stays high until select goes high.
- R7: After reset, primary register i (0 to 31) holds 0x80 plus i. The second register at word 16 holds 0xC0, the second register at word 17 holds 0xC1, and both toggle flags are 0.
- R8: Word addresses 16 and 17 (byte addresses 0x40 and 0x44) each have a toggle flag. A write goes to the primary register when the flag is 0 and to the second register when the flag is 1, and each completed write flips the flag. A read returns the register that the flag currently points to.
- R9: When address bit 7 is 1, a write changes nothing and a read returns 0x00.
- R10: `cfg_regs[8*i +: 8]` is primary register i for i from 0 to 31. Slice 32 is the second register at word 16, and slice 33 is the second register at word 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select, asynchronous to clk |
| sclk | input | 1 | Serial clock, asynchronous to clk, idles low |
| rw | input | 1 | Direction: 1 read, 0 write |
| sd_in | input | 1 | Serial data from host (input side of the data pad) |
| sd_out | output | 1 | Serial data to host during a read |
| sd_oe | output | 1 | Drive enable for the data pad; 0 means released |
| cfg_regs | output | 272 | All 34 registers, 8 bits each |

## Verification
The hardest state to reach from the ports is the toggle-flag position of the two paired addresses. It is visible only indirectly: through which slice of `cfg_regs` a write lands in, and through which register a read returns. The stimulus therefore interleaves writes and reads to both paired addresses and repeats reads to show that a read leaves the flag alone. It also drives transfers that stop short, transfers that overrun, and serial-clock activity while select is high. A behavioural model of the bank is compared against the register vector on every idle clock.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 8;
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int WORD_W     = 5;
  localparam int N_PRIM     = 1 << WORD_W;
  localparam int N_PAIR     = 2;
  localparam int N_REG      = N_PRIM + N_PAIR;
  localparam int IDX_W      = $clog2(N_REG);
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  // power-on contents of physical register idx
  function automatic logic [DATA_W-1:0] reg_reset(input int unsigned idx);
    if (idx < N_PRIM) return DATA_W'(8'h80 + idx);
    else              return DATA_W'(8'hC0 + (idx - N_PRIM));
  endfunction

  // map a word address and the toggle flags to a physical register index
  function automatic logic [IDX_W-1:0] phys_index(input logic [WORD_W-1:0] word,
                                                  input logic [N_PAIR-1:0] flags,
                                                  input int unsigned pair_a,
                                                  input int unsigned pair_b);
    if (word == WORD_W'(pair_a) && flags[0]) return IDX_W'(N_PRIM);
    if (word == WORD_W'(pair_b) && flags[1]) return IDX_W'(N_PRIM + 1);
    return IDX_W'(word);
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter import scp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sd_bit,
  input  logic              rw_bit,
  input  logic [DATA_W-1:0] rd_data,
  output logic [WORD_W-1:0] rd_word,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic [DATA_W-1:0] wr_data,
  output logic              sd_out,
  output logic              sd_oe,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              rd_mode
);
  localparam int SH_W = FRAME_BITS - 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);

  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] tx;
  logic              rd_void;

  // after ADDR_W shifts the address sits in the low bits of sh
  assign rd_void = sh[ADDR_W-1];
  assign rd_word = sh[ADDR_W-2 -: WORD_W];
  assign sd_out  = tx[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      rd_mode <= 1'b0;
      sd_oe   <= 1'b0;
      tx      <= '0;
      wr_en   <= 1'b0;
      wr_word <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        rd_mode <= 1'b0;
        sd_oe   <= 1'b0;
      end else begin
        if (sclk_rise && bit_cnt != CNT_FULL) begin
          sh      <= {sh[SH_W-2:0], sd_bit};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == '0) rd_mode <= rw_bit;
          if (bit_cnt == CNT_LAST && !rd_mode && !sh[SH_W-1]) begin
            wr_en   <= 1'b1;
            wr_word <= sh[SH_W-2 -: WORD_W];
            wr_data <= {sh[DATA_W-2:0], sd_bit};
          end
        end
        if (sclk_fall && rd_mode && bit_cnt >= CNT_ADDR) begin
          if (!sd_oe) begin
            sd_oe <= 1'b1;
            tx    <= rd_void ? '0 : rd_data;
          end else begin
            tx <= {tx[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/scp_bank.sv
module scp_bank import scp_pkg::*; #(
  parameter int unsigned PAIR_A = 16,
  parameter int unsigned PAIR_B = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [WORD_W-1:0]       wr_word,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [WORD_W-1:0]       rd_word,
  output logic [DATA_W-1:0]       rd_data,
  output logic [N_REG*DATA_W-1:0] cfg_flat,
  output logic [N_PAIR-1:0]       pair_flag
);
  logic [DATA_W-1:0] regs [N_REG];
  logic [IDX_W-1:0]  wr_tgt;
  logic [IDX_W-1:0]  rd_tgt;

  assign wr_tgt  = phys_index(wr_word, pair_flag, PAIR_A, PAIR_B);
  assign rd_tgt  = phys_index(rd_word, pair_flag, PAIR_A, PAIR_B);
  assign rd_data = regs[rd_tgt];

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   regs[i] <= reg_reset(i);
      else if (wr_en && wr_tgt == IDX_W'(i))        regs[i] <= wr_data;
    end
    assign cfg_flat[i*DATA_W +: DATA_W] = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_flag <= '0;
    end else if (wr_en) begin
      if (wr_word == WORD_W'(PAIR_A)) pair_flag[0] <= ~pair_flag[0];
      if (wr_word == WORD_W'(PAIR_B)) pair_flag[1] <= ~pair_flag[1];
    end
  end
endmodule

// File: rtl/scp_regif.sv
module scp_regif import scp_pkg::*; #(
  parameter int unsigned PAIR_A = 16,
  parameter int unsigned PAIR_B = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    rw,
  input  logic                    sd_in,
  output logic                    sd_out,
  output logic                    sd_oe,
  output logic [N_REG*DATA_W-1:0] cfg_regs
);
  // synchronised inputs: {cs_n, sclk, sd, rw}
  logic [3:0] raw_in, syn;
  logic       sclk_q;
  logic       cs_act, sclk_rise, sclk_fall;
  logic       wr_en;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rd_mode;
  logic [N_PAIR-1:0] pair_flag;

  assign raw_in = {cs_n, sclk, sd_in, rw};

  scp_sync #(.W(4), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= syn[2];
  end

  assign cs_act    = ~syn[3];
  assign sclk_rise =  syn[2] & ~sclk_q;
  assign sclk_fall = ~syn[2] &  sclk_q;

  scp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sd_bit(syn[1]), .rw_bit(syn[0]),
    .rd_data(rd_data), .rd_word(rd_word),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .sd_out(sd_out), .sd_oe(sd_oe),
    .bit_cnt(bit_cnt), .rd_mode(rd_mode)
  );

  scp_bank #(.PAIR_A(PAIR_A), .PAIR_B(PAIR_B)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .rd_word(rd_word), .rd_data(rd_data),
    .cfg_flat(cfg_regs), .pair_flag(pair_flag)
  );
endmodule

// File: rtl/scp_regif_chk.sv
module scp_regif_chk import scp_pkg::*; #(
  parameter int unsigned PAIR_A = 16,
  parameter int unsigned PAIR_B = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              sclk_fall,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_word,
  input logic              rd_mode,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              sd_oe,
  input logic [N_PAIR-1:0] pair_flag
);
  a_r4_commit_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> bit_cnt == CNT_W'(FRAME_BITS));
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS));
  a_r3_read_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_mode);
  a_r5_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sd_oe);
  a_r6_drive_after_address: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (rd_mode && bit_cnt >= CNT_W'(ADDR_W)));
  a_r6_drive_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> $past(sclk_fall));
  a_r8_flag_a_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == WORD_W'(PAIR_A)) |=> pair_flag[0] != $past(pair_flag[0]));
  a_r8_flag_b_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == WORD_W'(PAIR_B)) |=> pair_flag[1] != $past(pair_flag[1]));
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pair_flag));
endmodule

bind scp_regif scp_regif_chk #(.PAIR_A(PAIR_A), .PAIR_B(PAIR_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .wr_en(wr_en), .wr_word(wr_word), .rd_mode(rd_mode), .bit_cnt(bit_cnt),
  .sd_oe(sd_oe), .pair_flag(pair_flag)
);

// File: tb/scp_regif_tb.sv
`timescale 1ns/1ps
module scp_regif_tb;
  localparam int NR = 34;
  localparam int H  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, rw = 1'b0, sd_in = 1'b0;
  logic sd_out, sd_oe;
  logic [NR*8-1:0] cfg_regs;

  int checks = 0, fails = 0;
  bit done = 1'b0, cmp_en = 1'b0;
  logic [7:0] mreg [NR];
  bit mfl_a = 0, mfl_b = 0;

  always #2 clk = ~clk;

  scp_regif u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .rw(rw),
                   .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .cfg_regs(cfg_regs));

  function automatic logic [NR*8-1:0] model_vec();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = mreg[i];
    return v;
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // R10 / R1 / R4 / R5: register vector tracks the model on every idle clock
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (cfg_regs !== model_vec()) begin
        fails++;
        $display("FAIL R10 actual=%h expected=%h", cfg_regs, model_vec());
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_write(input logic [7:0] a, input logic [7:0] d);
    int w;
    if (a[7]) return;
    w = int'(a[6:2]);
    if (w == 16) begin
      if (mfl_a) mreg[32] = d; else mreg[16] = d;
      mfl_a = !mfl_a;
    end else if (w == 17) begin
      if (mfl_b) mreg[33] = d; else mreg[17] = d;
      mfl_b = !mfl_b;
    end else mreg[w] = d;
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a);
    int w;
    if (a[7]) return 8'h00;
    w = int'(a[6:2]);
    if (w == 16) return mfl_a ? mreg[32] : mreg[16];
    if (w == 17) return mfl_b ? mreg[33] : mreg[17];
    return mreg[w];
  endfunction

  task automatic xfer(input bit rd, input logic [7:0] a, input logic [7:0] d,
                      input int nbits, output logic [7:0] q);
    q = 8'h00;
    cmp_en = 1'b0;
    rw = rd; cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      sd_in = (i < 8) ? a[7-i] : ((i < 16) ? d[15-i] : 1'b1);
      wait_clk(H);
      if (rd && i >= 8 && i < 16) begin
        checks++;
        if (sd_oe !== 1'b1) begin
          fails++;
          $display("FAIL R6 actual=%b expected=1 (oe at bit %0d)", sd_oe, i);
        end
        q[15-i] = sd_out;
      end
      sclk = 1'b1;
      wait_clk(H);
      if (rd && i == 7) begin
        checks++;
        if (sd_oe !== 1'b0) begin
          fails++;
          $display("FAIL R6 actual=%b expected=0 (oe before first fall)", sd_oe);
        end
      end
      sclk = 1'b0;
    end
    wait_clk(H);
    if (rd && nbits >= 16) begin
      checks++;
      if (sd_oe !== 1'b1) begin
        fails++;
        $display("FAIL R6 actual=%b expected=1 (oe held to deselect)", sd_oe);
      end
    end
    cs_n = 1'b1;
    wait_clk(H);
    checks++;
    if (sd_oe !== 1'b0) begin
      fails++;
      $display("FAIL R5 actual=%b expected=0 (oe after deselect)", sd_oe);
    end
    if (!rd && nbits >= 16) m_write(a, d);
    cmp_en = 1'b1;
    wait_clk(2);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] q;
    xfer(1'b0, a, d, 16, q);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    logic [7:0] q;
    logic [7:0] e;
    e = m_read(a);
    xfer(1'b1, a, 8'h00, 16, q);
    chk8(req, q, e);
  endtask

  initial begin
    logic [7:0] q;
    for (int i = 0; i < NR; i++)
      mreg[i] = (i < 32) ? {3'b100, 5'(i)} : {7'b1100000, 1'(i - 32)};
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    // R7: reset contents
    chk8("R7", cfg_regs[5*8 +: 8], 8'h85);
    chk8("R7", cfg_regs[32*8 +: 8], 8'hC0);
    chk8("R7", cfg_regs[33*8 +: 8], 8'hC1);
    cmp_en = 1'b1;
    wait_clk(4);
    rd_chk("R7", 8'h14);
    // R1: plain write then read back
    wr(8'h0C, 8'h3C);
    rd_chk("R1", 8'h0C);
    // R2: low address bits ignored
    wr(8'h13, 8'hA7);
    rd_chk("R2", 8'h10);
    rd_chk("R2", 8'h12);
    // R3: reads leave the bank unchanged (vector compare runs throughout)
    rd_chk("R3", 8'h0C);
    rd_chk("R3", 8'h0C);
    // R4: short transfer commits nothing, long one uses first 16 bits
    xfer(1'b0, 8'h18, 8'h11, 10, q);
    xfer(1'b0, 8'h18, 8'h11, 15, q);
    rd_chk("R4", 8'h18);
    xfer(1'b0, 8'h1C, 8'h5A, 18, q);
    rd_chk("R4", 8'h1C);
    // R5: activity while deselected is ignored, next transfer aligns
    rw = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sd_in = i[0]; wait_clk(H); sclk = 1'b1; wait_clk(H); sclk = 1'b0;
    end
    checks++;
    if (sd_oe !== 1'b0) begin
      fails++;
      $display("FAIL R5 actual=%b expected=0", sd_oe);
    end
    wr(8'h20, 8'hC3);
    rd_chk("R5", 8'h20);
    // R8: paired addresses
    rd_chk("R8", 8'h40);
    wr(8'h40, 8'h01);
    rd_chk("R8", 8'h40);
    rd_chk("R8", 8'h40);
    wr(8'h41, 8'h02);
    chk8("R8", cfg_regs[16*8 +: 8], 8'h01);
    chk8("R8", cfg_regs[32*8 +: 8], 8'h02);
    rd_chk("R8", 8'h40);
    wr(8'h40, 8'h03);
    chk8("R8", cfg_regs[16*8 +: 8], 8'h03);
    wr(8'h44, 8'h04);
    rd_chk("R8", 8'h44);
    wr(8'h46, 8'h05);
    rd_chk("R8", 8'h44);
    chk8("R8", cfg_regs[33*8 +: 8], 8'h05);
    // R9: address bit 7 set
    wr(8'h8C, 8'hEE);
    rd_chk("R9", 8'h8C);
    rd_chk("R9", 8'h0C);
    // R1 / R10: assorted writes and reads
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a, d;
      a = 8'($urandom_range(0, 255));
      d = 8'($urandom_range(0, 255));
      wr(a, d);
      rd_chk("R1", a);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule